// File: doc/BRIEF.md
# Event Pending and Interrupt Aggregator

This block gathers single-cycle hardware event pulses into a small set of sticky pending words and turns them into three level-sensitive interrupt requests. Each event is named by a 7-bit code. The upper two bits of the code choose a pending word, and the lower five bits choose a bit inside that word. The bit then stays set until software clears it.

Three mask banks each hold one mask word per pending word. Each bank drives its own request line: the first bank drives the high-priority line, the second the middle line and the third the low line. A line is high whenever some pending bit is also enabled in the matching word of its bank. Software uses a single-cycle register port. It reads the pending and mask words with no side effect, clears pending bits by writing ones, and programs masks by plain writes.

Top module: `evt_irq_aggregator`

## Requirements
- R1: A valid event with code bits [6:5] = s (s < 3) and bits [4:0] = b sets bit b of pending word s at the next clock edge. All other bits already set in that word stay set.
- R2: A valid event whose code bits [6:5] equal 3 changes no pending bit.
- R3: A write to word offset 0, 1 or 2 clears each pending bit of that word whose write-data bit is 1. Bits written as 0 are unchanged. A set pending bit stays set until it is cleared this way.
- R4: When an event sets a bit and a write clears the same bit in the same cycle, the bit is set after that edge.
- R5: Mask words are read/write registers at word offsets 4-6 (bank A), 8-10 (bank B) and 12-14 (bank C). The offset minus the bank base selects pending word 0, 1 or 2. A write is visible on a read after the next edge.
- R6: irq_high is 1 exactly when some pending bit is also set in the same-indexed bank A mask word. irq_mid is the same test against bank B, and irq_low against bank C. After a mask write the line follows in the cycle after the edge.
- R7: Reads are combinational and return the addressed register. Offsets 3, 7, 11 and 15 read as zero, and writes to them change no register.
- R8: Reset clears all pending and mask words, so all three request lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | An event is presented this cycle |
| evt_code | input | 7 | Event code: [6:5] word select, [4:0] bit select |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq_high | output | 1 | High-priority request (bank A) |
| irq_mid | output | 1 | Middle-priority request (bank B) |
| irq_low | output | 1 | Low-priority request (bank C) |

## Verification
The hardest case to reach from the ports is an event and a software clear landing on the same pending bit in the same cycle. The bench drives this directly, with an all-ones clear aimed at the word the event targets. A long random phase then mixes events, clears, mask writes and out-of-range codes on every cycle so that such collisions happen many times. A reference model that applies the clear before the set is compared on every clock against the request lines and the read port.

// File: rtl/evt_agg_pkg.sv
package evt_agg_pkg;
   localparam int SEL_W     = 2;
   localparam int ADDR_W    = 4;
   localparam int NUM_BANKS = 3;
   localparam int LVL_HIGH  = 0;
   localparam int LVL_MID   = 1;
   localparam int LVL_LOW   = 2;

   typedef enum logic [1:0] {
      GRP_PEND   = 2'd0,
      GRP_MASK_A = 2'd1,
      GRP_MASK_B = 2'd2,
      GRP_MASK_C = 2'd3
   } reg_grp_e;
endpackage

// File: rtl/evt_pend_reg.sv
module evt_pend_reg #(
   parameter int REG_W = 32,
   localparam int BIT_W = $clog2(REG_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic [BIT_W-1:0] set_bit,
   input  logic             clr_en,
   input  logic [REG_W-1:0] clr_mask,
   output logic [REG_W-1:0] q
);
   logic [REG_W-1:0] set_vec;
   logic [REG_W-1:0] keep_vec;

   always_comb begin
      set_vec  = set_en ? (REG_W'(1) << set_bit) : '0;
      keep_vec = clr_en ? ~clr_mask : '1;
   end

   // the set term is ORed in after the clear so a colliding event survives
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (q & keep_vec) | set_vec;
   end
endmodule

// File: rtl/evt_mask_reg.sv
module evt_mask_reg #(
   parameter int REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [REG_W-1:0] d,
   output logic [REG_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
   end
endmodule

// File: rtl/evt_level_reduce.sv
module evt_level_reduce #(
   parameter int REG_W    = 32,
   parameter int NUM_REGS = 3,
   localparam int FLAT_W  = REG_W * NUM_REGS
) (
   input  logic [FLAT_W-1:0] pend_flat,
   input  logic [FLAT_W-1:0] mask_flat,
   output logic              req
);
   logic [NUM_REGS-1:0] word_hit;

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
      assign word_hit[r] = |(pend_flat[r*REG_W +: REG_W] & mask_flat[r*REG_W +: REG_W]);
   end

   assign req = |word_hit;
endmodule

// File: rtl/evt_irq_aggregator.sv
module evt_irq_aggregator
   import evt_agg_pkg::*;
#(
   parameter int REG_W    = 32,
   parameter int NUM_REGS = 3,
   localparam int BIT_W   = $clog2(REG_W),
   localparam int CODE_W  = SEL_W + BIT_W,
   localparam int FLAT_W  = REG_W * NUM_REGS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_valid,
   input  logic [CODE_W-1:0] evt_code,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   output logic              irq_high,
   output logic              irq_mid,
   output logic              irq_low
);
   if (NUM_REGS < 1 || NUM_REGS > 4) begin : g_bad_regs
      $error("NUM_REGS must be between 1 and 4");
   end
   if (REG_W < 2 || (REG_W & (REG_W - 1)) != 0) begin : g_bad_width
      $error("REG_W must be a power of two");
   end

   reg_grp_e         acc_grp;
   logic [1:0]       acc_idx;
   logic             acc_hit;
   logic [SEL_W-1:0] evt_sel;
   logic [BIT_W-1:0] evt_bit;
   logic             evt_ok;

   logic [FLAT_W-1:0]    pend_flat;
   logic [FLAT_W-1:0]    mask_flat [NUM_BANKS];
   logic [NUM_BANKS-1:0] irq_vec;

   assign acc_grp = reg_grp_e'(bus_addr[3:2]);
   assign acc_idx = bus_addr[1:0];
   assign acc_hit = int'(acc_idx) < NUM_REGS;
   assign evt_sel = evt_code[CODE_W-1 -: SEL_W];
   assign evt_bit = evt_code[BIT_W-1:0];
   assign evt_ok  = evt_valid && (int'(evt_sel) < NUM_REGS);

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_pend
      evt_pend_reg #(.REG_W(REG_W)) u_pend (
         .clk      (clk),
         .rst_n    (rst_n),
         .set_en   (evt_ok && evt_sel == SEL_W'(r)),
         .set_bit  (evt_bit),
         .clr_en   (bus_we && acc_grp == GRP_PEND && acc_idx == 2'(r)),
         .clr_mask (bus_wdata),
         .q        (pend_flat[r*REG_W +: REG_W])
      );
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
         evt_mask_reg #(.REG_W(REG_W)) u_mask (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bus_we && bus_addr[3:2] == 2'(b + 1) && acc_idx == 2'(r)),
            .d     (bus_wdata),
            .q     (mask_flat[b][r*REG_W +: REG_W])
         );
      end
      evt_level_reduce #(.REG_W(REG_W), .NUM_REGS(NUM_REGS)) u_reduce (
         .pend_flat (pend_flat),
         .mask_flat (mask_flat[b]),
         .req       (irq_vec[b])
      );
   end

   assign irq_high = irq_vec[LVL_HIGH];
   assign irq_mid  = irq_vec[LVL_MID];
   assign irq_low  = irq_vec[LVL_LOW];

   always_comb begin
      bus_rdata = '0;
      if (acc_hit) begin
         unique case (acc_grp)
            GRP_PEND:   bus_rdata = pend_flat[int'(acc_idx)*REG_W +: REG_W];
            GRP_MASK_A: bus_rdata = mask_flat[0][int'(acc_idx)*REG_W +: REG_W];
            GRP_MASK_B: bus_rdata = mask_flat[1][int'(acc_idx)*REG_W +: REG_W];
            GRP_MASK_C: bus_rdata = mask_flat[2][int'(acc_idx)*REG_W +: REG_W];
            default:    bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/evt_irq_aggregator_chk.sv
module evt_irq_aggregator_chk
   import evt_agg_pkg::*;
#(
   parameter int REG_W    = 32,
   parameter int NUM_REGS = 3,
   localparam int BIT_W   = $clog2(REG_W),
   localparam int CODE_W  = SEL_W + BIT_W,
   localparam int FLAT_W  = REG_W * NUM_REGS
) (
   input logic              clk,
   input logic              rst_n,
   input logic              evt_valid,
   input logic [CODE_W-1:0] evt_code,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [REG_W-1:0]  bus_wdata,
   input logic [REG_W-1:0]  bus_rdata,
   input logic              irq_high,
   input logic              irq_mid,
   input logic              irq_low,
   input logic [FLAT_W-1:0] pend_flat,
   input logic [FLAT_W-1:0] mask_flat [NUM_BANKS]
);
   logic [SEL_W-1:0] c_sel;
   logic             c_in_range;
   int               c_pos;

   assign c_sel      = evt_code[CODE_W-1 -: SEL_W];
   assign c_in_range = int'(c_sel) < NUM_REGS;
   assign c_pos      = int'(c_sel) * REG_W + int'(evt_code[BIT_W-1:0]);

   // R1 and R4: an accepted event bit is set after the edge, whatever is written
   assert_event_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && c_in_range) |=> pend_flat[$past(c_pos)]);

   assert_bad_code_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && !c_in_range && !bus_we) |=> $stable(pend_flat));

   assert_w1c_word0_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == '0 && !evt_valid) |=>
         ((pend_flat[REG_W-1:0] & $past(bus_wdata)) == '0));

   assert_pending_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_valid && !bus_we) |=> $stable(pend_flat));

   assert_mask_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == 4'd4) |=> (mask_flat[0][REG_W-1:0] == $past(bus_wdata)));

   assert_irq_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_high == (|(pend_flat & mask_flat[0])));
   assert_irq_mid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_mid == (|(pend_flat & mask_flat[1])));
   assert_irq_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_low == (|(pend_flat & mask_flat[2])));

   assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(bus_addr[1:0]) >= NUM_REGS) |-> (bus_rdata == '0));
endmodule

bind evt_irq_aggregator evt_irq_aggregator_chk #(
   .REG_W    (REG_W),
   .NUM_REGS (NUM_REGS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt_valid (evt_valid),
   .evt_code  (evt_code),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq_high  (irq_high),
   .irq_mid   (irq_mid),
   .irq_low   (irq_low),
   .pend_flat (pend_flat),
   .mask_flat (mask_flat)
);

// File: tb/tb_evt_irq_aggregator.sv
module tb_evt_irq_aggregator;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evt_valid = 1'b0;
   logic [6:0]  evt_code = '0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_high, irq_mid, irq_low;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] m_pend [3] = '{default: '0};
   logic [31:0] m_mask [3][3] = '{default: '{default: '0}};

   always #(CLK_PERIOD / 2) clk = ~clk;

   evt_irq_aggregator dut (
      .clk (clk), .rst_n (rst_n), .evt_valid (evt_valid), .evt_code (evt_code),
      .bus_we (bus_we), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata), .irq_high (irq_high), .irq_mid (irq_mid), .irq_low (irq_low)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] model_read(input logic [3:0] a);
      int g = int'(a[3:2]);
      int i = int'(a[1:0]);
      if (i == 3) return '0;
      if (g == 0) return m_pend[i];
      return m_mask[g-1][i];
   endfunction

   function automatic logic model_irq(input int bank);
      logic hit = 1'b0;
      for (int r = 0; r < 3; r++) hit |= |(m_pend[r] & m_mask[bank][r]);
      return hit;
   endfunction

   // reference model: clear first, then set, so a colliding event wins
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < 3; r++) begin
            m_pend[r] = '0;
            for (int b = 0; b < 3; b++) m_mask[b][r] = '0;
         end
      end else begin
         if (bus_we && bus_addr[1:0] != 2'd3) begin
            if (bus_addr[3:2] == 2'd0) m_pend[bus_addr[1:0]] &= ~bus_wdata;
            else m_mask[int'(bus_addr[3:2]) - 1][bus_addr[1:0]] = bus_wdata;
         end
         if (evt_valid && evt_code[6:5] != 2'd3)
            m_pend[evt_code[6:5]][evt_code[4:0]] = 1'b1;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R6 irq_high", 32'(irq_high), 32'(model_irq(0)));
         chk("R6 irq_mid",  32'(irq_mid),  32'(model_irq(1)));
         chk("R6 irq_low",  32'(irq_low),  32'(model_irq(2)));
         if (bus_addr[1:0] == 2'd3)       chk("R7 unmapped read", bus_rdata, model_read(bus_addr));
         else if (bus_addr[3:2] == 2'd0)  chk("R1 R3 pending read", bus_rdata, model_read(bus_addr));
         else                             chk("R5 mask read", bus_rdata, model_read(bus_addr));
      end
   end

   task automatic drive(input logic v, input logic [6:0] c, input logic we,
                        input logic [3:0] a, input logic [31:0] d);
      @(posedge clk);
      #1;
      evt_valid = v; evt_code = c; bus_we = we; bus_addr = a; bus_wdata = d;
   endtask

   task automatic read_at(input logic [3:0] a);
      drive(1'b0, 7'd0, 1'b0, a, 32'd0);
      @(negedge clk);
      #1;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R8: everything reads zero after reset, lines low
      for (int a = 0; a < 16; a++) begin
         read_at(4'(a));
         chk("R8 reset read", bus_rdata, 32'h0);
      end
      chk("R8 reset irq", {29'd0, irq_high, irq_mid, irq_low}, 32'h0);

      // R5: program one word in each bank
      drive(1'b0, 7'd0, 1'b1, 4'd4, 32'h0000_0010);
      drive(1'b0, 7'd0, 1'b1, 4'd9, 32'h0000_0010);
      drive(1'b0, 7'd0, 1'b1, 4'd14, 32'h8000_0000);
      read_at(4'd4);  chk("R5 mask A0", bus_rdata, 32'h0000_0010);
      read_at(4'd9);  chk("R5 mask B1", bus_rdata, 32'h0000_0010);
      read_at(4'd14); chk("R5 mask C2", bus_rdata, 32'h8000_0000);
      read_at(4'd5);  chk("R5 mask A1 untouched", bus_rdata, 32'h0);

      // R1: set bits and keep earlier ones
      drive(1'b1, 7'h04, 1'b0, 4'd0, 32'd0);
      read_at(4'd0);  chk("R1 word0 bit4", bus_rdata, 32'h0000_0010);
      chk("R6 high asserted", 32'(irq_high), 32'd1);
      drive(1'b1, 7'h05, 1'b0, 4'd0, 32'd0);
      read_at(4'd0);  chk("R1 word0 keeps bit4", bus_rdata, 32'h0000_0030);
      drive(1'b1, 7'h5F, 1'b0, 4'd0, 32'd0);
      read_at(4'd2);  chk("R1 word2 bit31", bus_rdata, 32'h8000_0000);
      chk("R6 low asserted", 32'(irq_low), 32'd1);

      // R2: word select 3 is dropped
      drive(1'b1, 7'h7F, 1'b0, 4'd0, 32'd0);
      read_at(4'd0);  chk("R2 word0", bus_rdata, 32'h0000_0030);
      read_at(4'd1);  chk("R2 word1", bus_rdata, 32'h0);
      read_at(4'd2);  chk("R2 word2", bus_rdata, 32'h8000_0000);

      // R3: zeros do nothing, ones clear
      drive(1'b0, 7'd0, 1'b1, 4'd0, 32'h0);
      read_at(4'd0);  chk("R3 zero write", bus_rdata, 32'h0000_0030);
      drive(1'b0, 7'd0, 1'b1, 4'd0, 32'h0000_0010);
      read_at(4'd0);  chk("R3 clear bit4", bus_rdata, 32'h0000_0020);
      chk("R6 high dropped", 32'(irq_high), 32'd0);

      // R4: event and clear collide on word1 bit4
      drive(1'b1, 7'h24, 1'b1, 4'd1, 32'hFFFF_FFFF);
      read_at(4'd1);  chk("R4 set wins", bus_rdata, 32'h0000_0010);
      chk("R6 mid asserted", 32'(irq_mid), 32'd1);

      // R6: mask change acts on the line at once, pending stays
      drive(1'b0, 7'd0, 1'b1, 4'd9, 32'h0);
      read_at(4'd1);  chk("R6 mid masked off", 32'(irq_mid), 32'd0);
      drive(1'b0, 7'd0, 1'b1, 4'd9, 32'h0000_0010);
      read_at(4'd1);  chk("R6 mid unmasked", 32'(irq_mid), 32'd1);
      read_at(4'd1);  chk("R3 line held while pending", 32'(irq_mid), 32'd1);
      drive(1'b0, 7'd0, 1'b1, 4'd1, 32'h0000_0010);
      read_at(4'd1);  chk("R3 line drops on clear", 32'(irq_mid), 32'd0);

      // R7: unmapped offsets
      drive(1'b0, 7'd0, 1'b1, 4'd3, 32'hFFFF_FFFF);
      drive(1'b0, 7'd0, 1'b1, 4'd7, 32'hFFFF_FFFF);
      read_at(4'd3);  chk("R7 offset3", bus_rdata, 32'h0);
      read_at(4'd7);  chk("R7 offset7", bus_rdata, 32'h0);
      read_at(4'd11); chk("R7 offset11", bus_rdata, 32'h0);
      read_at(4'd15); chk("R7 offset15", bus_rdata, 32'h0);
      read_at(4'd0);  chk("R7 word0 untouched", bus_rdata, 32'h0000_0020);
      read_at(4'd4);  chk("R7 mask A0 untouched", bus_rdata, 32'h0000_0010);

      // mixed traffic, compared every cycle against the model
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] wd;
         wd = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : 32'($urandom) & 32'($urandom);
         drive(1'($urandom % 2), 7'($urandom), 1'($urandom % 4 == 0),
               4'($urandom), wd);
      end
      @(negedge clk);
      #1;
      finish_run();
   end
endmodule